// File: doc/BRIEF.md
# Conditional Compare Flag Unit

This block produces the integer condition flags (overflow, sign, zero, carry) for two kinds of operation. The first is a conditional compare. A 4-bit condition code is tested against the flags the unit already holds. If the test passes, the two operands are compared: they are subtracted and the difference is thrown away, but the flags it produces are kept. If the test fails, the flags are loaded from a 4-bit constant that comes with the operation. The second kind is a plain ALU operation (add, subtract, AND, OR). It writes a result and can be told to leave the flags untouched.

A sequence of conditional compares can fold several comparisons into one flag state without any branch. For an AND chain, each step is guarded by the condition the previous step should have met, and its constant carries the "false" flags. For an OR chain, each step is guarded by the inverse condition, and its constant carries the "true" flags. Operands are 64 bits wide. A width select makes the unit work on the low half instead (32 bits by default), and all four flags are then taken at that width.

The unit is one registered stage. An operation is offered with `in_valid`, and the flag register and result register update on that clock edge. `out_valid` follows one cycle later. The result sits in its own register and is never written back into an operand, so both sources stay intact.

Top module: `ccmp_flag_unit`

## Requirements
- R1: Synchronous active-high reset clears the flag register, the result register and `out_valid` to zero.
- R2: Operation code 0 (conditional compare) with a true condition sets the flags from `op_a - op_b`. OF is signed overflow, SF is the sign bit of the difference, ZF is set when the difference is zero, and CF is set when an unsigned borrow occurs.
- R3: A conditional compare whose condition is false loads the flags from `dflt`, with OF in bit 3, SF in bit 2, ZF in bit 1 and CF in bit 0. The flags output `flags_q` uses the same bit order.
- R4: The condition codes are: 0 OF, 1 !OF, 2 CF, 3 !CF, 4 ZF, 5 !ZF, 6 CF|ZF, 7 !(CF|ZF), 8 SF, 9 !SF, 12 SF!=OF, 13 SF==OF, 14 ZF|(SF!=OF), 15 !(ZF|(SF!=OF)). Each code is tested against the flags held before the operation.
- R5: Condition code 10 always holds and condition code 11 never holds.
- R6: Operation codes 1 (add) and 2 (subtract) write the sum or difference to `result`. They set OF to signed overflow, SF to the sign bit, ZF to zero-result, and CF to carry-out (add) or borrow (subtract).
- R7: Operation codes 3 (AND) and 4 (OR) write the bitwise result. They set SF and ZF from that result and clear OF and CF.
- R8: An ALU operation (codes 1 to 4) with `no_flags` high still writes `result`, but the flag register keeps its previous value.
- R9: With `wide` low, operands are taken from their low 32 bits, the upper 32 bits of `result` are zero, and all four flags are computed at 32 bits.
- R10: When `in_valid` is low, or when the operation code is 5, 6 or 7, neither the flags nor the result change.
- R11: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R12: A conditional compare never changes `result`, and it ignores `no_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered this cycle |
| op_sel | input | 3 | 0 cond. compare, 1 add, 2 sub, 3 AND, 4 OR, 5-7 no operation |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond | input | 4 | Condition code for the conditional compare |
| dflt | input | 4 | Flags loaded when the condition fails {OF,SF,ZF,CF} |
| no_flags | input | 1 | Suppress the flag write for ALU operations |
| wide | input | 1 | 1: full 64-bit width, 0: low 32 bits |
| out_valid | output | 1 | Registered copy of in_valid |
| flags_q | output | 4 | Flag register {OF,SF,ZF,CF} |
| result | output | 64 | Result register of the last ALU operation |

## Verification
The hardest state to reach is a conditional compare whose outcome depends on flag values that an earlier operation left behind. This matters most for the signed-ordering codes, which need SF and OF to differ, and so need a real signed overflow at the selected width. Random operands rarely produce overflow, equal operands or borrows at the 32-bit boundary. The stimulus therefore draws its operands from a pool that includes 0, all-ones, the two sign-boundary values of each width and copies of the other operand. It issues long unbroken chains, so each condition code sees flags produced by adds, subtracts, logic operations and constant loads. Directed AND and OR chains check the folded result of several comparisons.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic cf;
    } ccf_flags_t;

    typedef enum logic [2:0] {
        OPC_CMP = 3'd0,
        OPC_ADD = 3'd1,
        OPC_SUB = 3'd2,
        OPC_AND = 3'd3,
        OPC_OR  = 3'd4
    } ccf_op_e;

    // Condition base (code[3:1]); code[0] inverts the base test.
    typedef enum logic [2:0] {
        CB_OVF   = 3'd0,
        CB_CARRY = 3'd1,
        CB_ZERO  = 3'd2,
        CB_BELEQ = 3'd3,
        CB_SIGN  = 3'd4,
        CB_ALWAYS = 3'd5,
        CB_LESS  = 3'd6,
        CB_LESSEQ = 3'd7
    } ccf_cbase_e;

    function automatic logic op_is_alu(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd4);
    endfunction

    function automatic logic op_is_known(input logic [2:0] op);
        return op <= 3'd4;
    endfunction

endpackage

// File: rtl/ccf_cond_eval.sv
module ccf_cond_eval
    import ccf_pkg::*;
(
    input  logic [3:0] cond,
    input  ccf_flags_t cur,
    output logic       holds
);
    ccf_cbase_e base;
    logic       base_true;

    always_comb begin
        base = ccf_cbase_e'(cond[3:1]);
        case (base)
            CB_OVF:    base_true = cur.of;
            CB_CARRY:  base_true = cur.cf;
            CB_ZERO:   base_true = cur.zf;
            CB_BELEQ:  base_true = cur.cf | cur.zf;
            CB_SIGN:   base_true = cur.sf;
            CB_ALWAYS: base_true = 1'b1;
            CB_LESS:   base_true = cur.sf ^ cur.of;
            CB_LESSEQ: base_true = cur.zf | (cur.sf ^ cur.of);
            default:   base_true = 1'b0;
        endcase
        holds = base_true ^ cond[0];
    end
endmodule

// File: rtl/ccf_alu.sv
module ccf_alu
    import ccf_pkg::*;
#(
    parameter int DW = 64,
    parameter int NW = DW / 2
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          wide,
    output logic [DW-1:0] res,
    output ccf_flags_t    flg
);
    localparam int HI = DW - NW;

    logic [DW-1:0] mask;
    logic [DW-1:0] a_m, b_m, raw;
    logic [DW:0]   sum_x, dif_x;
    logic          sa, sb, sr, cy, bw;

    // Width mask built bit by bit from the selected width.
    for (genvar i = 0; i < DW; i++) begin : g_mask
        if (i < NW) begin : g_lo
            assign mask[i] = 1'b1;
        end else begin : g_hi
            assign mask[i] = wide;
        end
    end

    always_comb begin
        a_m   = a & mask;
        b_m   = b & mask;
        sum_x = {1'b0, a_m} + {1'b0, b_m};
        dif_x = {1'b0, a_m} - {1'b0, b_m};
        cy    = wide ? sum_x[DW] : sum_x[NW];
        bw    = wide ? dif_x[DW] : dif_x[NW];
        sa    = wide ? a_m[DW-1] : a_m[NW-1];
        sb    = wide ? b_m[DW-1] : b_m[NW-1];

        case (op)
            OPC_ADD: raw = sum_x[DW-1:0];
            OPC_AND: raw = a_m & b_m;
            OPC_OR:  raw = a_m | b_m;
            default: raw = dif_x[DW-1:0];
        endcase
        res = raw & mask;
        sr  = wide ? res[DW-1] : res[NW-1];

        flg.sf = sr;
        flg.zf = (res == '0);
        case (op)
            OPC_ADD: begin
                flg.cf = cy;
                flg.of = (sa == sb) && (sr != sa);
            end
            OPC_AND, OPC_OR: begin
                flg.cf = 1'b0;
                flg.of = 1'b0;
            end
            default: begin
                flg.cf = bw;
                flg.of = (sa != sb) && (sr != sa);
            end
        endcase
    end

    logic unused_hi;
    assign unused_hi = ^{HI};
endmodule

// File: rtl/ccf_flag_sel.sv
module ccf_flag_sel
    import ccf_pkg::*;
(
    input  logic       in_valid,
    input  logic [2:0] op,
    input  logic       cond_ok,
    input  logic       no_flags,
    input  ccf_flags_t alu_flags,
    input  logic [3:0] dflt,
    output ccf_flags_t next_flags,
    output logic       flag_we,
    output logic       res_we
);
    always_comb begin
        next_flags = alu_flags;
        flag_we    = 1'b0;
        res_we     = 1'b0;
        if (in_valid && op_is_known(op)) begin
            if (op == OPC_CMP) begin
                flag_we = 1'b1;
                if (!cond_ok) begin
                    next_flags = ccf_flags_t'(dflt);
                end
            end else begin
                res_we  = 1'b1;
                flag_we = !no_flags;
            end
        end
    end
endmodule

// File: rtl/ccmp_flag_unit.sv
module ccmp_flag_unit
    import ccf_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    op_sel,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [3:0]    cond,
    input  logic [3:0]    dflt,
    input  logic          no_flags,
    input  logic          wide,
    output logic          out_valid,
    output logic [3:0]    flags_q,
    output logic [DW-1:0] result
);
    ccf_flags_t    flg_r, flg_n, alu_f;
    logic [DW-1:0] alu_res, res_r;
    logic          cond_ok, flag_we, res_we, vld_r;

    ccf_cond_eval u_cond (
        .cond  (cond),
        .cur   (flg_r),
        .holds (cond_ok)
    );

    ccf_alu #(.DW(DW)) u_alu (
        .op   (op_sel),
        .a    (op_a),
        .b    (op_b),
        .wide (wide),
        .res  (alu_res),
        .flg  (alu_f)
    );

    ccf_flag_sel u_sel (
        .in_valid   (in_valid),
        .op         (op_sel),
        .cond_ok    (cond_ok),
        .no_flags   (no_flags),
        .alu_flags  (alu_f),
        .dflt       (dflt),
        .next_flags (flg_n),
        .flag_we    (flag_we),
        .res_we     (res_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_r <= '0;
            res_r <= '0;
            vld_r <= 1'b0;
        end else begin
            vld_r <= in_valid;
            if (flag_we) flg_r <= flg_n;
            if (res_we)  res_r <= alu_res;
        end
    end

    assign out_valid = vld_r;
    assign flags_q   = flg_r;
    assign result    = res_r;
endmodule

// File: rtl/ccf_checker.sv
module ccf_checker #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [2:0]    op_sel,
    input logic [3:0]    cond,
    input logic [3:0]    dflt,
    input logic          no_flags,
    input logic          wide,
    input logic          out_valid,
    input logic [3:0]    flags_q,
    input logic [DW-1:0] result
);
    localparam int NW = DW / 2;

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || op_sel > 3'd4) |=> ($stable(flags_q) && $stable(result)));
    assert_never_true_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd0 && cond == 4'd11) |=> (flags_q == $past(dflt)));
    assert_fail_load_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd0 && cond == 4'd5 && flags_q[1]) |=> (flags_q == $past(dflt)));
    assert_suppress_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && no_flags && op_sel >= 3'd1 && op_sel <= 3'd4) |=> $stable(flags_q));
    assert_cmp_keeps_result_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd0) |=> $stable(result));
    assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide && op_sel >= 3'd1 && op_sel <= 3'd4) |=> (result[DW-1:NW] == '0));
    assert_logic_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !no_flags && (op_sel == 3'd3 || op_sel == 3'd4)) |=> (!flags_q[3] && !flags_q[0]));
endmodule

bind ccmp_flag_unit ccf_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .cond      (cond),
    .dflt      (dflt),
    .no_flags  (no_flags),
    .wide      (wide),
    .out_valid (out_valid),
    .flags_q   (flags_q),
    .result    (result)
);

// File: tb/sim_ccmp_flag_unit.sv
`timescale 1ns/1ps
module sim_ccmp_flag_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_sel;
    logic [63:0] op_a, op_b;
    logic [3:0]  cond, dflt;
    logic        no_flags, wide;
    logic        out_valid;
    logic [3:0]  flags_q;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0]  m_flags;
    logic [63:0] m_res;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ccmp_flag_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .op_a(op_a), .op_b(op_b), .cond(cond), .dflt(dflt),
        .no_flags(no_flags), .wide(wide), .out_valid(out_valid),
        .flags_q(flags_q), .result(result)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Condition test written directly from the code table.
    function automatic bit ref_cond(input logic [3:0] cc, input logic [3:0] f);
        bit o = f[3], s = f[2], z = f[1], c = f[0];
        case (cc)
            4'd0:  return o;
            4'd1:  return !o;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return z;
            4'd5:  return !z;
            4'd6:  return c || z;
            4'd7:  return !(c || z);
            4'd8:  return s;
            4'd9:  return !s;
            4'd10: return 1;
            4'd11: return 0;
            4'd12: return s != o;
            4'd13: return s == o;
            4'd14: return z || (s != o);
            default: return !(z || (s != o));
        endcase
    endfunction

    function automatic void ref_alu(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                                    input bit w, output logic [63:0] r, output logic [3:0] f);
        bit o, s, z, c;
        if (w) begin
            logic signed [64:0] ss;
            case (op)
                3'd1: begin r = a + b; c = (r < a); ss = $signed({a[63], a}) + $signed({b[63], b}); o = ss[64] != ss[63]; end
                3'd3: begin r = a & b; c = 0; o = 0; end
                3'd4: begin r = a | b; c = 0; o = 0; end
                default: begin r = a - b; c = (a < b); ss = $signed({a[63], a}) - $signed({b[63], b}); o = ss[64] != ss[63]; end
            endcase
            s = r[63];
        end else begin
            logic [31:0] a3, b3, r3;
            logic signed [32:0] s3;
            a3 = a[31:0]; b3 = b[31:0];
            case (op)
                3'd1: begin r3 = a3 + b3; c = (r3 < a3); s3 = $signed({a3[31], a3}) + $signed({b3[31], b3}); o = s3[32] != s3[31]; end
                3'd3: begin r3 = a3 & b3; c = 0; o = 0; end
                3'd4: begin r3 = a3 | b3; c = 0; o = 0; end
                default: begin r3 = a3 - b3; c = (a3 < b3); s3 = $signed({a3[31], a3}) - $signed({b3[31], b3}); o = s3[32] != s3[31]; end
            endcase
            r = {32'd0, r3};
            s = r3[31];
        end
        z = (r == 64'd0);
        f = {o, s, z, c};
    endfunction

    // Drive one cycle at the falling edge, then check after the next rising edge.
    task automatic step(input bit v, input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [3:0] cc, input logic [3:0] df, input bit nf, input bit w);
        logic [63:0] r;
        logic [3:0]  f;
        string rq_f, rq_r;
        @(negedge clk);
        in_valid = v; op_sel = op; op_a = a; op_b = b; cond = cc; dflt = df; no_flags = nf; wide = w;
        rq_f = "R10"; rq_r = "R10";
        if (v && op == 3'd0) begin
            rq_r = "R12";
            if (ref_cond(cc, m_flags)) begin
                ref_alu(3'd2, a, b, w, r, f);
                m_flags = f;
                rq_f = (cc == 4'd10) ? "R5" : (w ? "R2" : "R9");
            end else begin
                m_flags = df;
                rq_f = (cc == 4'd11) ? "R5" : "R3";
            end
        end else if (v && op >= 3'd1 && op <= 3'd4) begin
            ref_alu(op, a, b, w, r, f);
            m_res = r;
            rq_r = !w ? "R9" : ((op >= 3'd3) ? "R7" : "R6");
            if (nf) rq_f = "R8";
            else begin
                m_flags = f;
                rq_f = !w ? "R9" : ((op >= 3'd3) ? "R7" : "R6");
            end
        end
        @(posedge clk);
        #1;
        chk(out_valid == v, "R11", {63'd0, out_valid}, {63'd0, v});
        chk(flags_q == m_flags, rq_f, {60'd0, flags_q}, {60'd0, m_flags});
        chk(result == m_res, rq_r, result, m_res);
        if (v && op == 3'd0 && cc != 4'd10 && cc != 4'd11)
            chk(flags_q == m_flags, "R4", {60'd0, flags_q}, {60'd0, m_flags});
    endtask

    function automatic logic [63:0] pick(input logic [63:0] other);
        case ($urandom_range(0, 9))
            0: return 64'd0;
            1: return '1;
            2: return 64'h8000_0000_0000_0000;
            3: return 64'h7fff_ffff_ffff_ffff;
            4: return 64'h0000_0000_8000_0000;
            5: return 64'h0000_0000_7fff_ffff;
            6: return other;
            7: return {$urandom(), $urandom()} & 64'hff;
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3b_77a5));
        rst = 1; in_valid = 0; op_sel = 0; op_a = 0; op_b = 0; cond = 0; dflt = 0; no_flags = 0; wide = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk(flags_q == 4'd0, "R1", {60'd0, flags_q}, 64'd0);
        chk(result == 64'd0, "R1", result, 64'd0);
        chk(out_valid == 1'b0, "R1", {63'd0, out_valid}, 64'd0);
        m_flags = 4'd0; m_res = 64'd0;

        // R2/R5: always-true compare of equal operands sets ZF
        step(1, 3'd0, 64'd5, 64'd5, 4'd10, 4'hf, 0, 1);
        chk(flags_q == 4'b0010, "R2", {60'd0, flags_q}, 64'h2);
        // AND chain: second compare guarded by ZF (code 4), fail constant 0
        step(1, 3'd0, 64'd9, 64'd9, 4'd4, 4'h0, 0, 1);
        chk(flags_q[1] == 1'b1, "R4", {63'd0, flags_q[1]}, 64'd1);
        step(1, 3'd0, 64'd9, 64'd8, 4'd4, 4'h0, 0, 1);
        step(1, 3'd0, 64'd1, 64'd1, 4'd4, 4'h0, 0, 1);
        chk(flags_q == 4'h0, "R3", {60'd0, flags_q}, 64'h0);
        // OR chain: guarded by NE (code 5), fail constant carries ZF
        step(1, 3'd0, 64'd3, 64'd3, 4'd10, 4'h0, 0, 1);
        step(1, 3'd0, 64'd7, 64'd2, 4'd5, 4'b0010, 0, 1);
        chk(flags_q == 4'b0010, "R3", {60'd0, flags_q}, 64'h2);
        // R8: add with flags suppressed, then R12 compare ignores no_flags
        step(1, 3'd1, '1, 64'd1, 4'd0, 4'd0, 1, 1);
        chk(result == 64'd0, "R8", result, 64'd0);
        step(1, 3'd0, 64'd1, 64'd2, 4'd10, 4'd0, 1, 1);
        chk(flags_q == 4'b0101, "R12", {60'd0, flags_q}, 64'h5);
        // R9: narrow overflow at 32 bits
        step(1, 3'd1, 64'hffff_ffff_7fff_ffff, 64'd1, 4'd0, 4'd0, 0, 0);
        chk(flags_q == 4'b1100, "R9", {60'd0, flags_q}, 64'hc);
        // R10: reserved op and idle cycle
        step(1, 3'd6, 64'd4, 64'd4, 4'd10, 4'd0, 0, 1);
        step(0, 3'd1, 64'd4, 64'd4, 4'd10, 4'd0, 0, 1);
        // R5: code 11 never holds
        step(1, 3'd0, 64'd4, 64'd4, 4'd11, 4'b1001, 0, 1);
        chk(flags_q == 4'b1001, "R5", {60'd0, flags_q}, 64'h9);

        for (int i = 0; i < 1500; i++) begin
            logic [63:0] a, b;
            logic [2:0]  op;
            a = pick(64'd0);
            b = pick(a);
            op = ($urandom_range(0, 9) < 4) ? 3'd0 : 3'($urandom_range(1, 7));
            step($urandom_range(0, 9) != 0, op, a, b, 4'($urandom()), 4'($urandom()),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 2) != 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule